// File: doc/BRIEF.md
# Packing Receive FIFO for a Short-Frame SPI Port

This block buffers frames of up to 8 bits coming out of an SPI shift register and hands them to the bus side. Four frame slots, 32 bits in all, hold the data. The bus can take one frame per read with a byte access, or two consecutive frames per read with a half-word access. In a half-word access the older frame lands in the low byte.

A receive-not-empty flag drives both the interrupt and the DMA request. Its threshold is selectable between one frame and two frames. The fill level is reported as a frame count from 0 to 4, where each frame is a quarter of the capacity.

Under continuous reception a frame can arrive in the same cycle as a pop. Level, pointers and flag all account for both events together, so the flag never announces a pair that is not fully stored.

Top module: `spi_pack_rx_fifo`

## Requirements
- R1: While `rst_ni` is low, the FIFO becomes empty: `level_o`=0, `rxne_o`=0, `ovr_o`=0 and `rd_data_o`=0. The block stays in that state after reset is released.
- R2: `level_o` holds the number of stored frames: 0 empty, 1 quarter, 2 half, 3 three quarters, 4 full. It updates at the clock edge that performs a push or a pop.
- R3: When `thr_wide_i`=0 (threshold of one frame), `rxne_o` is 1 after an edge exactly when at least one frame is stored.
- R4: When `thr_wide_i`=1 (threshold of two frames), `rxne_o` is 1 only when at least two frames are stored. A half-word read at level 3 leaves level 1 with `rxne_o`=0.
- R5: With `rd_wide_i`=1 and at least two frames stored, `rd_data_o[7:0]` is the oldest frame and `rd_data_o[15:8]` the next one. A read pops both, and later reads return the following frames in order.
- R6: With `rd_wide_i`=0, `rd_data_o[7:0]` is the oldest frame and `rd_data_o[15:8]` is 0. A read pops exactly one frame.
- R7: A half-word read with one frame stored returns that frame in `[7:0]`, with 0 in `[15:8]`, and pops only that frame. With no frames stored it returns 0 and changes nothing.
- R8: A frame accepted in the same cycle as a pop is counted together with it. A half-word read with a push at level 3 gives level 2, and `rxne_o` follows the new level.
- R9: A frame arriving at level 4 with no pop in that cycle is dropped and sets the sticky `ovr_o`. `ovr_clr_i` clears `ovr_o`, but a drop in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | Received frame strobe from the shifter |
| frame_data_i | input | 8 | Received frame |
| rd_en_i | input | 1 | Bus read strobe (pops at the clock edge) |
| rd_wide_i | input | 1 | Access size: 1 half-word (two frames), 0 byte |
| thr_wide_i | input | 1 | Flag threshold: 1 two frames, 0 one frame |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 16 | Read data for the access size, combinational from the head |
| rxne_o | output | 1 | Receive-not-empty flag (interrupt and DMA request) |
| level_o | output | 3 | Stored frame count, 0 to 4 |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Read data is combinational from the head entries, so the bench drives a read on the falling edge and samples `rd_data_o` before the next rising edge that pops it. `level_o`, `rxne_o` and `ovr_o` are registered and take their new value at the rising edge that performs the push, pop or drop. The bench reads them shortly after that edge. `rxne_o` uses the threshold present at that same edge, so the bench sets `thr_wide_i` at least one edge before it checks the flag.

// File: rtl/spi_pack_rx_pkg.sv
package spi_pack_rx_pkg;
  localparam int unsigned FRAME_W = 8;
  typedef enum logic {ACC_BYTE = 1'b0, ACC_HALF = 1'b1} acc_e;
endpackage

// File: rtl/rx_ptr_ctrl.sv
module rx_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_vld_i,
  input  logic          rd_en_i,
  input  logic          rd_wide_i,
  output logic          push_o,
  output logic          drop_o,
  output logic [1:0]    pop_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_d_o
);
  import spi_pack_rx_pkg::*;

  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic has1, has2, full;

  always_comb begin
    has1 = cnt_q != '0;
    has2 = cnt_q >= CW'(2);
    full = cnt_q == CW'(DEPTH);
    pop_o = 2'd0;
    if (rd_en_i) begin
      if (acc_e'(rd_wide_i) == ACC_HALF) pop_o = has2 ? 2'd2 : {1'b0, has1};
      else                              pop_o = {1'b0, has1};
    end
    // a slot freed in the same cycle lets the frame in
    push_o  = frame_vld_i && (!full || pop_o != 2'd0);
    drop_o  = frame_vld_i && full && pop_o == 2'd0;
    cnt_d_o = cnt_q - CW'(pop_o) + CW'(push_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + PW'(push_o);
      rd_q  <= rd_q + PW'(pop_o);
      cnt_q <= cnt_d_o;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign cnt_o    = cnt_q;

  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> $stable(rd_q));
  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && frame_vld_i && !rd_en_i) |=> (cnt_q == CW'(DEPTH) && $stable(wr_q)));
endmodule

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FW = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wa_i,
  input  logic [FW-1:0] wd_i,
  input  logic [PW-1:0] ra_i,
  output logic [FW-1:0] rd0_o,
  output logic [FW-1:0] rd1_o
);
  logic [FW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[i] <= '0;
      else if (we_i && wa_i == PW'(i))    mem_q[i] <= wd_i;
    end
  end

  logic [PW-1:0] ra_nxt;
  assign ra_nxt = ra_i + PW'(1);
  assign rd0_o  = mem_q[ra_i];
  assign rd1_o  = mem_q[ra_nxt];
endmodule

// File: rtl/rx_flag_gen.sv
module rx_flag_gen #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic          thr_wide_i,
  input  logic          drop_i,
  input  logic          ovr_clr_i,
  output logic          rxne_o,
  output logic          ovr_o
);
  logic rxne_q, ovr_q;

  // flag follows the post-update level so a same-cycle push and pop are both seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxne_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      rxne_q <= thr_wide_i ? (cnt_d_i >= CW'(2)) : (cnt_d_i != '0);
      if (drop_i)         ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign rxne_o = rxne_q;
  assign ovr_o  = ovr_q;

  p_rxne_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(thr_wide_i) |-> (rxne_q == (cnt_i != '0)));
  p_rxne_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(thr_wide_i) |-> (rxne_q == (cnt_i >= CW'(2))));
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q);
endmodule

// File: rtl/spi_pack_rx_fifo.sv
module spi_pack_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FW = spi_pack_rx_pkg::FRAME_W,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_vld_i,
  input  logic [FW-1:0]   frame_data_i,
  input  logic            rd_en_i,
  input  logic            rd_wide_i,
  input  logic            thr_wide_i,
  input  logic            ovr_clr_i,
  output logic [2*FW-1:0] rd_data_o,
  output logic            rxne_o,
  output logic [CW-1:0]   level_o,
  output logic            ovr_o
);
  logic          push, drop;
  logic [1:0]    pop;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_d;
  logic [FW-1:0] rd0, rd1;

  rx_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .frame_vld_i, .rd_en_i, .rd_wide_i,
    .push_o(push), .drop_o(drop), .pop_o(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .cnt_o(cnt), .cnt_d_o(cnt_d)
  );

  rx_byte_store #(.DEPTH(DEPTH), .FW(FW)) u_store (
    .clk_i, .rst_ni, .we_i(push), .wa_i(wr_ptr), .wd_i(frame_data_i),
    .ra_i(rd_ptr), .rd0_o(rd0), .rd1_o(rd1)
  );

  rx_flag_gen #(.CW(CW)) u_flag (
    .clk_i, .rst_ni, .cnt_i(cnt), .cnt_d_i(cnt_d), .thr_wide_i,
    .drop_i(drop), .ovr_clr_i, .rxne_o, .ovr_o
  );

  assign rd_data_o[FW-1:0]    = (cnt != '0) ? rd0 : '0;
  assign rd_data_o[2*FW-1:FW] = (rd_wide_i && cnt >= CW'(2)) ? rd1 : '0;
  assign level_o = cnt;

  p_pair_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_wide_i && level_o >= CW'(2) && !frame_vld_i) |=> (level_o == $past(level_o) - CW'(2)));
  p_byte_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_wide_i && level_o != '0 && !frame_vld_i) |=> (level_o == $past(level_o) - CW'(1)));
  p_same_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_wide_i && level_o >= CW'(2) && frame_vld_i) |=> (level_o == $past(level_o) - CW'(1)));
  p_hi_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_wide_i |-> (rd_data_o[2*FW-1:FW] == '0));
endmodule

// File: tb/spi_pack_rx_fifo_test.sv
`timescale 1ns/1ps
module spi_pack_rx_fifo_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame_vld_i = 0, rd_en_i = 0, rd_wide_i = 0, thr_wide_i = 0, ovr_clr_i = 0;
  logic [7:0] frame_data_i = '0;
  logic [15:0] rd_data_o;
  logic rxne_o, ovr_o;
  logic [2:0] level_o;
  int errors = 0, checks = 0;
  logic [15:0] snap;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  spi_pack_rx_fifo uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, snapshot read data before the edge, settle after
  task automatic cyc(input bit vld, input logic [7:0] d, input bit rd, input bit wide, input bit clr);
    @(negedge clk_i);
    frame_vld_i = vld; frame_data_i = d; rd_en_i = rd; rd_wide_i = wide; ovr_clr_i = clr;
    #1 snap = rd_data_o;
    @(posedge clk_i); #1;
    frame_vld_i = 0; rd_en_i = 0; ovr_clr_i = 0;
  endtask

  task automatic push(input logic [7:0] d); cyc(1, d, 0, 0, 0); endtask

  task automatic do_reset();
    rst_ni = 0; #12; rst_ni = 1; @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(level_o == 0 && rxne_o == 0 && ovr_o == 0, "R1 reset state", {level_o, rxne_o, ovr_o}, 0);
    chk(rd_data_o == 0, "R1 reset data", rd_data_o, 0);
    push(8'h01); push(8'h02);
    rst_ni = 0; #3;
    chk(level_o == 0 && rxne_o == 0, "R1 mid-run reset", {level_o, rxne_o}, 0);
    rst_ni = 1; @(posedge clk_i); #1;
  endtask

  task automatic t_byte_thr();
    thr_wide_i = 0;
    push(8'h41);
    chk(level_o == 1, "R2 level after push", level_o, 1);
    chk(rxne_o == 1, "R3 rxne one frame", rxne_o, 1);
    thr_wide_i = 1; cyc(0, 0, 0, 0, 0);
    chk(rxne_o == 0, "R4 rxne one frame wide thr", rxne_o, 0);
    thr_wide_i = 0; cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk(snap == 16'h0041, "R6 byte read data", snap, 16'h0041);
    chk(level_o == 0 && rxne_o == 0, "R3 empty after byte read", {level_o, rxne_o}, 0);
  endtask

  task automatic t_byte_order();
    thr_wide_i = 0;
    push(8'h51); push(8'h52);
    cyc(0, 0, 1, 0, 0);
    chk(snap == 16'h0051 && level_o == 1, "R6 byte pop one", {snap, 5'b0, level_o}, {16'h0051, 8'h01});
    cyc(0, 0, 1, 0, 0);
    chk(snap == 16'h0052 && level_o == 0, "R6 byte pop second", {snap, 5'b0, level_o}, {16'h0052, 8'h00});
  endtask

  task automatic t_pack();
    thr_wide_i = 1; cyc(0, 0, 0, 0, 0);
    push(8'hA1);
    chk(rxne_o == 0, "R4 one frame no rxne", rxne_o, 0);
    push(8'hB2);
    chk(rxne_o == 1 && level_o == 2, "R4 two frames rxne", {rxne_o, level_o}, {1'b1, 3'd2});
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'hB2A1, "R5 packed order", snap, 16'hB2A1);
    chk(level_o == 0 && rxne_o == 0, "R5 pair popped", {level_o, rxne_o}, 0);
  endtask

  task automatic t_three_quarter();
    thr_wide_i = 1;
    push(8'h31); push(8'h32); push(8'h33);
    chk(level_o == 3, "R2 level three", level_o, 3);
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h3231, "R5 read at three", snap, 16'h3231);
    chk(level_o == 1 && rxne_o == 0, "R4 level one rxne low", {level_o, rxne_o}, {3'd1, 1'b0});
    push(8'h34);
    chk(rxne_o == 1, "R4 rxne back", rxne_o, 1);
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h3433, "R5 alignment kept", snap, 16'h3433);
  endtask

  task automatic t_same_cycle();
    thr_wide_i = 1;
    push(8'h21); push(8'h22); push(8'h23);
    cyc(1, 8'h24, 1, 1, 0);
    chk(snap == 16'h2221, "R8 read data", snap, 16'h2221);
    chk(level_o == 2 && rxne_o == 1, "R8 level and rxne", {level_o, rxne_o}, {3'd2, 1'b1});
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h2423, "R8 following pair", snap, 16'h2423);
    chk(level_o == 0 && rxne_o == 0, "R8 empty", {level_o, rxne_o}, 0);
  endtask

  task automatic t_underfill();
    thr_wide_i = 0;
    push(8'h5A);
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h005A && level_o == 0, "R7 wide read one frame", {snap, 5'b0, level_o}, {16'h005A, 8'h00});
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h0000 && level_o == 0, "R7 wide read empty", {snap, 5'b0, level_o}, 0);
    push(8'h6B); push(8'h6C);
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h6C6B, "R7 no pointer slip", snap, 16'h6C6B);
  endtask

  task automatic t_overrun();
    thr_wide_i = 1;
    push(8'h10); push(8'h11); push(8'h12); push(8'h13);
    chk(level_o == 4 && ovr_o == 0, "R2 full", {level_o, ovr_o}, {3'd4, 1'b0});
    push(8'hEE);
    chk(level_o == 4 && ovr_o == 1, "R9 drop sets ovr", {level_o, ovr_o}, {3'd4, 1'b1});
    cyc(1, 8'hEF, 0, 0, 1);
    chk(ovr_o == 1, "R9 drop wins over clear", ovr_o, 1);
    cyc(0, 0, 0, 0, 1);
    chk(ovr_o == 0, "R9 clear", ovr_o, 0);
    cyc(1, 8'h14, 1, 1, 0);
    chk(snap == 16'h1110 && level_o == 3 && ovr_o == 0, "R9 full read frees slot",
        {snap, 4'b0, level_o, ovr_o}, {16'h1110, 4'b0, 3'd3, 1'b0});
    cyc(0, 0, 1, 1, 0);
    chk(snap == 16'h1312, "R9 dropped frame absent", snap, 16'h1312);
    cyc(0, 0, 1, 0, 0);
    chk(snap == 16'h0014 && level_o == 0, "R9 last frame", {snap, 5'b0, level_o}, {16'h0014, 8'h00});
  endtask

  initial begin
    t_reset();
    t_byte_thr();
    t_byte_order();
    t_pack();
    t_three_quarter();
    t_same_cycle();
    t_underfill();
    t_overrun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule